// File: doc/BRIEF.md
# Stereo DAC Channel Mixer with Soft Mute

This block sits between a received stereo sample pair and one stereo DAC data path. Each accepted sample pair is routed onto the left and right outputs by a 4-bit routing code. A lane can carry the left input, the right input, the arithmetic mean of both, or silence. Straight stereo pass-through uses code `1001`.

After routing, each output lane goes through a soft-mute stage. When a mute is requested, the lane does not cut to zero. On every new sample it decays geometrically from its last value, with a time constant of about 64 samples, and it ends exactly at zero. A mute is requested by the channel mute bit, by the global mute-all bit, or by an automatic zero detector. When enabled, the zero detector raises a flag after a long run of all-zero input pairs. Releasing the mute returns the lane to pass-through on the next sample.

Top module: `dac_mix_smute`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid`, `out_left`, `out_right` and `zero_flag` are all 0.
- R2: A pair accepted with `in_valid` at rising edge k produces its result on the outputs after edge k+1. `out_valid` is high for exactly that one cycle.
- R3: The left output source is picked by `route_code[1:0]`: 00 gives zero, 01 the left input, 10 the right input, 11 the mean.
- R4: The right output source is picked by `route_code[3:2]`: 00 gives zero, 01 the left input, and 10 or 11 the right input.
- R5: The mean is floor((L+R)/2) on two's-complement samples. It is computed one bit wider than a sample, so it never overflows, including at full-scale inputs.
- R6: While a mute request (`ch_mute`, `mute_all` or `zero_flag`) is high, each new sample replaces a lane value y with y − s. Here s = floor(y/64), except that s = 1 when 0 < y < 64. The lane magnitude therefore strictly falls until it reaches 0 and then stays at 0.
- R7: `mute_all` has the same effect as `ch_mute`.
- R8: The first sample processed with no mute request outputs the routed value directly, with no ramp.
- R9: With `autozero_en` high, `zero_flag` rises after the 1024th consecutive accepted pair in which both inputs are zero. Cycles without `in_valid` neither count nor break the run.
- R10: `zero_flag` falls after the first accepted pair that has any nonzero input, and it stays 0 while `autozero_en` is low.
- R11: Outputs hold their values in cycles where `out_valid` is low. Input data presented without `in_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for the input pair |
| in_left | input | W | Left input sample, two's complement |
| in_right | input | W | Right input sample, two's complement |
| route_code | input | 4 | Routing code: [1:0] picks the left source, [3:2] picks the right source |
| ch_mute | input | 1 | Channel soft-mute request |
| mute_all | input | 1 | Global soft-mute request |
| autozero_en | input | 1 | Enables the zero-run detector and its automute |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | W | Processed left sample |
| out_right | output | W | Processed right sample |
| zero_flag | output | 1 | Long zero run detected |

## Verification
The soft-mute lane value is carried forward from one sample to the next. A wrong step or a wrong clamp therefore shows up on the first muted sample and keeps drifting from the expected curve on every later one. It may also stop short of zero, which leaves a constant offset that never clears. A wrong zero-run count only shows up at the 1024th zero pair, or when the first nonzero pair fails to clear the flag. For that reason the bench checks the flag at the exact boundary sample. Routing or mean errors show up on the very next `out_valid`. Full-scale mean cases are driven specifically so that any loss of the extra sum bit is seen.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int ROUTE_W = 4;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_LEFT  = 2'd1,
    SRC_RIGHT = 2'd2,
    SRC_MEAN  = 2'd3
  } src_e;

  // Left lane: low two code bits map directly onto a source.
  function automatic src_e left_src(input logic [ROUTE_W-1:0] code);
    return src_e'(code[1:0]);
  endfunction

  // Right lane: bit 3 selects the right input, else bit 2 selects left.
  function automatic src_e right_src(input logic [ROUTE_W-1:0] code);
    if (code[3])      return SRC_RIGHT;
    else if (code[2]) return SRC_LEFT;
    else              return SRC_ZERO;
  endfunction
endpackage

// File: rtl/dmx_route.sv
module dmx_route
  import dmx_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_vld,
  input  logic signed [W-1:0]   smp_l,
  input  logic signed [W-1:0]   smp_r,
  input  logic [ROUTE_W-1:0]    code,
  output logic                  st_vld,
  output logic signed [W-1:0]   st_l,
  output logic signed [W-1:0]   st_r
);
  localparam int SW    = W + 1;
  localparam int LANES = 2;

  logic signed [SW-1:0] sum;
  logic signed [W-1:0]  mean;
  src_e                 sel  [LANES];
  logic signed [W-1:0]  pick [LANES];
  logic signed [W-1:0]  q    [LANES];

  // One guard bit keeps the sum exact; dropping the LSB is floor division.
  assign sum    = $signed({smp_l[W-1], smp_l}) + $signed({smp_r[W-1], smp_r});
  assign mean   = sum[SW-1:1];
  assign sel[0] = left_src(code);
  assign sel[1] = right_src(code);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (sel[g])
        SRC_LEFT:  pick[g] = smp_l;
        SRC_RIGHT: pick[g] = smp_r;
        SRC_MEAN:  pick[g] = mean;
        default:   pick[g] = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst)          q[g] <= '0;
      else if (smp_vld) q[g] <= pick[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_vld <= 1'b0;
    else     st_vld <= smp_vld;
  end

  assign st_l = q[0];
  assign st_r = q[1];
endmodule

// File: rtl/dmx_zero_det.sv
module dmx_zero_det #(
  parameter int RUN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_vld,
  input  logic pair_zero,
  input  logic enable,
  output logic flag
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt, cnt_nx;

  // Saturating run length of all-zero pairs; gaps leave it unchanged.
  always_comb begin
    cnt_nx = cnt;
    if (smp_vld) begin
      if (!pair_zero)             cnt_nx = '0;
      else if (cnt != CW'(RUN))   cnt_nx = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      flag <= enable && (cnt_nx == CW'(RUN));
    end
  end
endmodule

// File: rtl/dmx_soft_mute.sv
module dmx_soft_mute #(
  parameter int W     = 24,
  parameter int SHIFT = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd,
  input  logic                mute,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] y, step;

  // Geometric step; forced to one LSB for small positives so the lane lands on zero.
  always_comb begin
    step = y >>> SHIFT;
    if (step == '0 && y > 0) step = {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst)      y <= '0;
    else if (upd) y <= mute ? (y - step) : din;
  end

  assign dout = y;
endmodule

// File: rtl/dac_mix_smute.sv
module dac_mix_smute
  import dmx_pkg::*;
#(
  parameter int W           = 24,
  parameter int ZERO_RUN    = 1024,
  parameter int DECAY_SHIFT = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_left,
  input  logic signed [W-1:0] in_right,
  input  logic [3:0]          route_code,
  input  logic                ch_mute,
  input  logic                mute_all,
  input  logic                autozero_en,
  output logic                out_valid,
  output logic signed [W-1:0] out_left,
  output logic signed [W-1:0] out_right,
  output logic                zero_flag
);
  localparam int LANES = 2;

  logic                st_vld;
  logic signed [W-1:0] st_l, st_r;
  logic                zf;
  logic                mute_req;
  logic signed [W-1:0] lane_in  [LANES];
  logic signed [W-1:0] lane_out [LANES];

  dmx_route #(.W(W)) u_route (
    .clk    (clk),
    .rst    (rst),
    .smp_vld(in_valid),
    .smp_l  (in_left),
    .smp_r  (in_right),
    .code   (route_code),
    .st_vld (st_vld),
    .st_l   (st_l),
    .st_r   (st_r)
  );

  dmx_zero_det #(.RUN(ZERO_RUN)) u_zdet (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (in_valid),
    .pair_zero((in_left == '0) && (in_right == '0)),
    .enable   (autozero_en),
    .flag     (zf)
  );

  assign mute_req   = ch_mute | mute_all | zf;
  assign lane_in[0] = st_l;
  assign lane_in[1] = st_r;

  for (genvar g = 0; g < LANES; g++) begin : g_mute
    dmx_soft_mute #(.W(W), .SHIFT(DECAY_SHIFT)) u_sm (
      .clk (clk),
      .rst (rst),
      .upd (st_vld),
      .mute(mute_req),
      .din (lane_in[g]),
      .dout(lane_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= st_vld;
  end

  assign out_left  = lane_out[0];
  assign out_right = lane_out[1];
  assign zero_flag = zf;
endmodule

// File: rtl/dmx_checker.sv
module dmx_checker #(
  parameter int W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic signed [W-1:0] in_left,
  input logic signed [W-1:0] in_right,
  input logic [3:0]          route_code,
  input logic                ch_mute,
  input logic                mute_all,
  input logic                autozero_en,
  input logic                out_valid,
  input logic signed [W-1:0] out_left,
  input logic signed [W-1:0] out_right,
  input logic                zero_flag
);
  logic [1:0]          cyc;
  logic [3:0]          code_d1, code_d2;
  logic signed [W-1:0] last_l, last_r;
  logic                req_now;

  assign req_now = ch_mute || mute_all || zero_flag;

  function automatic logic [W:0] mag(input logic signed [W-1:0] v);
    logic signed [W:0] e;
    e = v;
    return (e < 0) ? -e : e;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc     <= '0;
      code_d1 <= '0;
      code_d2 <= '0;
      last_l  <= '0;
      last_r  <= '0;
    end else begin
      if (cyc != 2'd2) cyc <= cyc + 1'b1;
      code_d1 <= route_code;
      code_d2 <= code_d1;
      if (out_valid) begin
        last_l <= out_left;
        last_r <= out_right;
      end
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  a_r3_code_zero: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd2 && out_valid && !$past(req_now) && code_d2[1:0] == 2'b00) |-> (out_left == '0));

  a_r4_code_zero: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd2 && out_valid && !$past(req_now) && code_d2[3:2] == 2'b00) |-> (out_right == '0));

  a_r6_left_shrinks: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(req_now) && last_l != '0) |-> (mag(out_left) < mag(last_l)));

  a_r6_right_shrinks: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(req_now) && last_r != '0) |-> (mag(out_right) < mag(last_r)));

  a_r6_left_stays_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(req_now) && last_l == '0) |-> (out_left == '0));

  a_r6_right_stays_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(req_now) && last_r == '0) |-> (out_right == '0));

  a_r10_clear_on_data: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && ($past(in_left) != '0 || $past(in_right) != '0)) |-> !zero_flag);

  a_r10_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(autozero_en) |-> !zero_flag);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));
endmodule

bind dac_mix_smute dmx_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_left    (in_left),
  .in_right   (in_right),
  .route_code (route_code),
  .ch_mute    (ch_mute),
  .mute_all   (mute_all),
  .autozero_en(autozero_en),
  .out_valid  (out_valid),
  .out_left   (out_left),
  .out_right  (out_right),
  .zero_flag  (zero_flag)
);

// File: tb/tb_dac_mix_smute.sv
module tb_dac_mix_smute;
  localparam int W    = 24;
  localparam int RUN  = 1024;
  localparam int VMAX = (1 << (W - 1)) - 1;
  localparam int VMIN = -(1 << (W - 1));

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_left = '0, in_right = '0;
  logic [3:0]          route_code = 4'b1001;
  logic                ch_mute = 1'b0, mute_all = 1'b0, autozero_en = 1'b0;
  logic                out_valid, zero_flag;
  logic signed [W-1:0] out_left, out_right;

  int    total = 0, bad = 0;
  bit    done = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  dac_mix_smute dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .route_code(route_code), .ch_mute(ch_mute), .mute_all(mute_all),
    .autozero_en(autozero_en), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right), .zero_flag(zero_flag)
  );

  // ---------------- behavioural reference ----------------
  int m_ov, m_v1, m_zf, zrun;
  int s1[2];
  int ey[2];

  function automatic int floor_half(int s);
    return (s >= 0) ? s / 2 : -((-s + 1) / 2);
  endfunction

  function automatic int pick(int src, int l, int r);
    case (src)
      0: return 0;
      1: return l;
      2: return r;
      default: return floor_half(l + r);
    endcase
  endfunction

  function automatic int decay(int y);
    int s;
    s = (y >= 0) ? y / 64 : -((-y + 63) / 64);
    if (s == 0 && y > 0) s = 1;
    return y - s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ov = 0; m_v1 = 0; m_zf = 0; zrun = 0;
      s1[0] = 0; s1[1] = 0; ey[0] = 0; ey[1] = 0;
    end else begin
      int req, l, r, c;
      req = (ch_mute || mute_all || m_zf) ? 1 : 0;
      if (m_v1 != 0)
        for (int k = 0; k < 2; k++) ey[k] = req ? decay(ey[k]) : s1[k];
      m_ov = m_v1;
      m_v1 = in_valid ? 1 : 0;
      if (in_valid) begin
        l = int'(in_left); r = int'(in_right); c = int'(route_code);
        s1[0] = pick(c % 4, l, r);
        s1[1] = pick((c >= 8) ? 2 : (((c / 4) % 2 == 1) ? 1 : 0), l, r);
        if (l == 0 && r == 0) begin
          if (zrun < RUN) zrun++;
        end else zrun = 0;
      end
      m_zf = (autozero_en && zrun >= RUN) ? 1 : 0;
    end
  end

  task automatic chk(input string t, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, "out_valid", int'(out_valid), m_ov);
      chk(tag, "out_left",  int'(out_left),  ey[0]);
      chk(tag, "out_right", int'(out_right), ey[1]);
      chk(tag, "zero_flag", int'(zero_flag), m_zf);
    end
  end

  task automatic smp(input int l, input int r, input int gap);
    in_valid = 1'b1;
    in_left  = W'(l);
    in_right = W'(r);
    @(negedge clk);
    in_valid = 1'b0;
    in_left  = W'(24'h5A5A5A);   // junk without strobe, must be ignored (R11)
    in_right = W'(24'hA5A5A5);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R2 watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "out_left",  int'(out_left),  0);
    chk("R1", "zero_flag", int'(zero_flag), 0);
    rst = 1'b0;

    // Routing matrix with gaps: R2 R3 R4 R5 R11
    tag = "R2 R3 R4 R5 R11";
    for (int c = 0; c < 16; c++) begin
      route_code = 4'(c);
      smp(1000, -3000, c % 3);
      smp(VMAX, VMAX, 0);
      smp(VMIN, VMIN, 1);
      smp(VMAX, VMIN, 0);
      smp(-1, -2, 2);
      smp(-7, 4, 0);
    end

    // Channel soft mute, decay and release: R6 R8
    tag = "R6 R8";
    route_code = 4'b1001;
    repeat (10) smp(5000000, -6000000, 0);
    ch_mute = 1'b1;
    repeat (400) smp(5000000, -6000000, 0);
    ch_mute = 1'b0;
    smp(123456, -654321, 1);
    chk("R8", "release_left", int'(out_left), 123456);
    repeat (3) smp(300, -250, 0);
    ch_mute = 1'b1;
    repeat (500) smp(300, -250, 1);
    chk("R6", "decayed_left",  int'(out_left),  0);
    chk("R6", "decayed_right", int'(out_right), 0);
    ch_mute = 1'b0;
    smp(-40, 41, 0);

    // Global mute: R7 R6 R8
    tag = "R7 R6 R8";
    route_code = 4'b0111;
    repeat (5) smp(-8000000, 2000000, 0);
    mute_all = 1'b1;
    repeat (200) smp(-8000000, 2000000, 0);
    mute_all = 1'b0;
    repeat (5) smp(9, -9, 0);

    // Zero-run detector: R9 R10 R6
    tag = "R9 R10 R6";
    route_code = 4'b1001;
    autozero_en = 1'b1;
    for (int i = 0; i < RUN - 1; i++) smp(0, 0, (i % 97 == 0) ? 2 : 0);
    @(negedge clk);
    chk("R9", "flag_before_run", int'(zero_flag), 0);
    smp(0, 0, 0);
    chk("R9", "flag_at_run", int'(zero_flag), 1);
    repeat (20) smp(0, 0, 0);
    smp(7, 0, 0);
    chk("R10", "flag_cleared", int'(zero_flag), 0);
    autozero_en = 1'b0;
    for (int i = 0; i < RUN + 20; i++) smp(0, 0, 0);
    chk("R10", "flag_disabled", int'(zero_flag), 0);
    smp(5, 6, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule